// File: doc/BRIEF.md
# Manual Symbol Detect and Burst Abort Controller

This block lets a host force two events in a burst-mode spread-spectrum receiver: a symbol correlation detect and an abort of the burst in progress. Both run in the IF clock domain and are paced by a one-cycle baseband sample strobe. Each event has two sources: an external pin and a control register bit. The two are ORed together, the result is synchronized, and a rising edge of the combined signal arms the event. The event then fires on the second baseband strobe that follows.

A fired detect produces a one-cycle detect pulse. Downstream, this pulse moves the I and Q correlator outputs to the demodulator. A fired abort produces a one-cycle abort pulse, which sends the receiver back to acquisition. The abort also clears three burst-tracking counters: symbols in the burst, samples in the current symbol, and detects missed in the burst. The counters then stay idle until an automatic preamble detect or a manual detect starts them again.

Top module: `mdab_ctrl`

## Requirements
- R1: A detect trigger edge is accepted only while `det_en` is 1. If `det_en` is 0 for any clock, a detect that is waiting is cancelled and gives no pulse.
- R2: For each function, the pin and the register bit are ORed. A rising edge on one input arms the function only while the other input is 0. A rise on one input while the other is 1 has no effect.
- R3: The trigger is recognised within SYNC_STAGES+1 clocks. `det_pulse` is then high for exactly one clock: the clock that follows the edge at which the second `bb_stb` after recognition is sampled.
- R4: The abort path is independent of the detect path and has the same timing. `abort_pulse` is high for one clock following the second `bb_stb` after recognition.
- R5: An abort clears `sym_cnt`, `smp_cnt` and `miss_cnt` to 0 and drops `cnt_active` at the same edge that raises `abort_pulse`. If a detect (manual or preamble) takes effect at that same edge, the abort wins.
- R6: While `cnt_active` is 0, strobes leave all three counters unchanged.
- R7: A detect (manual pulse, or `preamble_det` high at a clock edge) sets `cnt_active`, clears `smp_cnt` and increments `sym_cnt`. `sym_cnt` saturates at its all-ones value.
- R8: When `cnt_active` is 1, each `bb_stb` without a detect increments `smp_cnt`. When `smp_cnt`+1 reaches `sym_len`, `smp_cnt` returns to 0 instead and `miss_cnt` increments. `miss_cnt` saturates at its all-ones value.
- R9: After reset, both pulses are 0, `cnt_active` is 0 and all counters are 0.
- R10: A new trigger edge while a function is already waiting is ignored. The wait is not restarted, and the pulse comes on the second strobe after the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | IF clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bb_stb | input | 1 | Baseband sample strobe, one clock wide |
| det_en | input | 1 | Manual detect enable |
| det_pin | input | 1 | External manual detect request |
| det_reg | input | 1 | Register manual detect request |
| abort_pin | input | 1 | External abort request |
| abort_reg | input | 1 | Register abort request |
| preamble_det | input | 1 | Automatic preamble detect event |
| sym_len | input | SMP_W | Nominal samples per symbol |
| det_pulse | output | 1 | Correlation detect pulse |
| abort_pulse | output | 1 | Burst abort pulse |
| cnt_active | output | 1 | Burst counters running |
| sym_cnt | output | CNT_W | Symbols in burst |
| smp_cnt | output | SMP_W | Samples in current symbol |
| miss_cnt | output | CNT_W | Missed detects in burst |

## Verification
The hardest case to reach is an abort and a detect taking effect at the same edge. The bench raises the detect pin and the abort register bit together, so both paths wait through the same strobes and fire together. It also lines up a waiting abort with a strobe that carries a preamble detect. A second hard case is a trigger edge that arrives while a function is already waiting. Here the bench holds one strobe's worth of progress, re-raises the pin, and checks that the very next strobe still fires.

// File: rtl/mdab_pkg.sv
package mdab_pkg;
    typedef enum logic [1:0] {
        PEND_IDLE  = 2'd0,
        PEND_ARMED = 2'd1,
        PEND_HALF  = 2'd2
    } pend_e;

    localparam int unsigned N_FUNC  = 2;
    localparam int unsigned FN_DET  = 0;
    localparam int unsigned FN_ABRT = 1;
endpackage

// File: rtl/mdab_trig_sync.sv
module mdab_trig_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_a,
    input  logic req_b,
    output logic rise
);
    localparam int unsigned TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.chain[0] = req_a | req_b;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
        s_d.last = s_q.chain[TOP];
        rise     = s_q.chain[TOP] & ~s_q.last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/mdab_strobe_delay.sv
module mdab_strobe_delay
    import mdab_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic rise,
    input  logic stb,
    output logic fire
);
    typedef struct packed {
        pend_e st;
    } pend_t;

    pend_t p_d, p_q;

    always_comb begin
        p_d  = p_q;
        fire = 1'b0;
        if (!enable) begin
            p_d.st = PEND_IDLE;
        end else begin
            case (p_q.st)
                PEND_IDLE:  if (rise) p_d.st = PEND_ARMED;
                PEND_ARMED: if (stb)  p_d.st = PEND_HALF;
                PEND_HALF: begin
                    if (stb) begin
                        p_d.st = PEND_IDLE;
                        fire   = 1'b1;
                    end
                end
                default:    p_d.st = PEND_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '{st: PEND_IDLE};
        else        p_q <= p_d;
    end
endmodule

// File: rtl/mdab_burst_cnt.sv
module mdab_burst_cnt #(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned SMP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic             det_evt,
    input  logic             abort_evt,
    input  logic [SMP_W-1:0] sym_len,
    output logic             active,
    output logic [CNT_W-1:0] sym_cnt,
    output logic [SMP_W-1:0] smp_cnt,
    output logic [CNT_W-1:0] miss_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] sym;
        logic [SMP_W-1:0] smp;
        logic [CNT_W-1:0] miss;
    } cnt_t;

    cnt_t c_d, c_q;
    logic [SMP_W:0] smp_next;

    always_comb begin
        c_d      = c_q;
        smp_next = {1'b0, c_q.smp} + 1'b1;
        if (abort_evt) begin
            c_d = '0;
        end else if (det_evt) begin
            c_d.active = 1'b1;
            c_d.smp    = '0;
            if (c_q.sym != CNT_MAX) c_d.sym = c_q.sym + 1'b1;
        end else if (c_q.active && stb) begin
            if (smp_next >= {1'b0, sym_len}) begin
                c_d.smp = '0;
                if (c_q.miss != CNT_MAX) c_d.miss = c_q.miss + 1'b1;
            end else begin
                c_d.smp = smp_next[SMP_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign active   = c_q.active;
    assign sym_cnt  = c_q.sym;
    assign smp_cnt  = c_q.smp;
    assign miss_cnt = c_q.miss;
endmodule

// File: rtl/mdab_ctrl.sv
module mdab_ctrl
    import mdab_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned SMP_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bb_stb,
    input  logic             det_en,
    input  logic             det_pin,
    input  logic             det_reg,
    input  logic             abort_pin,
    input  logic             abort_reg,
    input  logic             preamble_det,
    input  logic [SMP_W-1:0] sym_len,
    output logic             det_pulse,
    output logic             abort_pulse,
    output logic             cnt_active,
    output logic [CNT_W-1:0] sym_cnt,
    output logic [SMP_W-1:0] smp_cnt,
    output logic [CNT_W-1:0] miss_cnt
);
    typedef struct packed {
        logic det;
        logic abrt;
    } pulse_t;

    logic [N_FUNC-1:0] src_pin, src_reg, fn_en, fn_rise, fn_fire;
    pulse_t o_d, o_q;

    assign src_pin[FN_DET]  = det_pin;
    assign src_reg[FN_DET]  = det_reg;
    assign fn_en[FN_DET]    = det_en;
    assign src_pin[FN_ABRT] = abort_pin;
    assign src_reg[FN_ABRT] = abort_reg;
    assign fn_en[FN_ABRT]   = 1'b1;

    for (genvar f = 0; f < N_FUNC; f++) begin : g_func
        mdab_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .req_a (src_pin[f]),
            .req_b (src_reg[f]),
            .rise  (fn_rise[f])
        );
        mdab_strobe_delay u_dly (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (fn_en[f]),
            .rise   (fn_rise[f]),
            .stb    (bb_stb),
            .fire   (fn_fire[f])
        );
    end

    mdab_burst_cnt #(.CNT_W(CNT_W), .SMP_W(SMP_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (bb_stb),
        .det_evt   (fn_fire[FN_DET] | preamble_det),
        .abort_evt (fn_fire[FN_ABRT]),
        .sym_len   (sym_len),
        .active    (cnt_active),
        .sym_cnt   (sym_cnt),
        .smp_cnt   (smp_cnt),
        .miss_cnt  (miss_cnt)
    );

    always_comb begin
        o_d      = o_q;
        o_d.det  = fn_fire[FN_DET];
        o_d.abrt = fn_fire[FN_ABRT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign det_pulse   = o_q.det;
    assign abort_pulse = o_q.abrt;
endmodule

// File: rtl/mdab_ctrl_chk.sv
module mdab_ctrl_chk #(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned SMP_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bb_stb,
    input logic             det_en,
    input logic             det_pulse,
    input logic             abort_pulse,
    input logic             cnt_active,
    input logic [CNT_W-1:0] sym_cnt,
    input logic [SMP_W-1:0] smp_cnt,
    input logic [CNT_W-1:0] miss_cnt
);
    // R1
    det_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_pulse |-> $past(det_en));
    // R3
    det_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_pulse |-> $past(bb_stb));
    // R3
    det_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_pulse |=> !det_pulse);
    // R4
    abort_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> $past(bb_stb));
    // R5
    abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> (!cnt_active && sym_cnt == '0 && smp_cnt == '0 && miss_cnt == '0));
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_active && !$past(cnt_active)) |->
            ($stable(sym_cnt) && $stable(smp_cnt) && $stable(miss_cnt)));
    // R7
    det_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (det_pulse && !abort_pulse) |-> (cnt_active && smp_cnt == '0));
endmodule

bind mdab_ctrl mdab_ctrl_chk #(.CNT_W(CNT_W), .SMP_W(SMP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bb_stb      (bb_stb),
    .det_en      (det_en),
    .det_pulse   (det_pulse),
    .abort_pulse (abort_pulse),
    .cnt_active  (cnt_active),
    .sym_cnt     (sym_cnt),
    .smp_cnt     (smp_cnt),
    .miss_cnt    (miss_cnt)
);

// File: tb/mdab_ctrl_test.sv
`timescale 1ns/1ps
module mdab_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bb_stb = 1'b0, det_en = 1'b0, det_pin = 1'b0, det_reg = 1'b0;
    logic       abort_pin = 1'b0, abort_reg = 1'b0, preamble_det = 1'b0;
    logic [7:0] sym_len = 8'd3;
    logic       det_pulse, abort_pulse, cnt_active;
    logic [7:0] sym_cnt, smp_cnt, miss_cnt;
    int         checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    mdab_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bb_stb(bb_stb), .det_en(det_en),
        .det_pin(det_pin), .det_reg(det_reg), .abort_pin(abort_pin),
        .abort_reg(abort_reg), .preamble_det(preamble_det), .sym_len(sym_len),
        .det_pulse(det_pulse), .abort_pulse(abort_pulse), .cnt_active(cnt_active),
        .sym_cnt(sym_cnt), .smp_cnt(smp_cnt), .miss_cnt(miss_cnt)
    );

    // vector: [14] strobe, [13] preamble, [12] active, [11:8] smp, [7:4] miss, [3:0] sym
    localparam int NV = 11;
    localparam logic [14:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 4'd0, 4'd0, 4'd0},
        {1'b0, 1'b1, 1'b1, 4'd0, 4'd0, 4'd1},
        {1'b1, 1'b0, 1'b1, 4'd1, 4'd0, 4'd1},
        {1'b1, 1'b0, 1'b1, 4'd2, 4'd0, 4'd1},
        {1'b1, 1'b0, 1'b1, 4'd0, 4'd1, 4'd1},
        {1'b0, 1'b0, 1'b1, 4'd0, 4'd1, 4'd1},
        {1'b1, 1'b0, 1'b1, 4'd1, 4'd1, 4'd1},
        {1'b1, 1'b1, 1'b1, 4'd0, 4'd1, 4'd2},
        {1'b1, 1'b0, 1'b1, 4'd1, 4'd1, 4'd2},
        {1'b1, 1'b0, 1'b1, 4'd2, 4'd1, 4'd2},
        {1'b1, 1'b0, 1'b1, 4'd0, 4'd2, 4'd2}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input logic s, input logic p);
        @(negedge clk);
        bb_stb = s;
        preamble_det = p;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0);
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        // R9 reset state
        chk("R9", "det_pulse", det_pulse, 0);
        chk("R9", "abort_pulse", abort_pulse, 0);
        chk("R9", "cnt_active", cnt_active, 0);
        chk("R9", "counters", sym_cnt | smp_cnt | miss_cnt, 0);
        @(negedge clk); rst_n = 1'b1;
        idle(2);

        // R6 R7 R8 counter vectors, sym_len = 3
        for (int v = 0; v < NV; v++) begin
            step(VEC[v][14], VEC[v][13]);
            chk("R6/R7", "active", cnt_active, int'(VEC[v][12]));
            chk("R8", "smp_cnt", smp_cnt, int'(VEC[v][11:8]));
            chk("R8", "miss_cnt", miss_cnt, int'(VEC[v][7:4]));
            chk("R7", "sym_cnt", sym_cnt, int'(VEC[v][3:0]));
        end

        // R3 manual detect from the pin
        det_en = 1'b1; det_pin = 1'b1;
        idle(5);
        chk("R3", "no pulse before strobes", det_pulse, 0);
        step(1'b1, 1'b0);
        chk("R3", "no pulse on first strobe", det_pulse, 0);
        step(1'b1, 1'b0);
        chk("R3", "pulse on second strobe", det_pulse, 1);
        chk("R7", "sym_cnt after manual detect", sym_cnt, 3);
        chk("R7", "smp_cnt after manual detect", smp_cnt, 0);
        step(1'b0, 1'b0);
        chk("R3", "pulse one cycle", det_pulse, 0);
        det_pin = 1'b0;
        idle(5);

        // R2 register bit path, then rise on pin while register bit high
        det_reg = 1'b1;
        idle(5);
        step(1'b1, 1'b0); step(1'b1, 1'b0);
        chk("R2", "register bit triggers", det_pulse, 1);
        det_pin = 1'b1;
        idle(5);
        step(1'b1, 1'b0);
        chk("R2", "masked rise first strobe", det_pulse, 0);
        step(1'b1, 1'b0);
        chk("R2", "masked rise second strobe", det_pulse, 0);
        det_pin = 1'b0; det_reg = 1'b0;
        idle(5);

        // R10 second edge while waiting is ignored
        det_pin = 1'b1;
        idle(5);
        step(1'b1, 1'b0);
        det_pin = 1'b0; idle(5);
        det_pin = 1'b1; idle(5);
        step(1'b1, 1'b0);
        chk("R10", "fires on original schedule", det_pulse, 1);
        det_pin = 1'b0;
        idle(5);

        // R1 disabled edge ignored, and cancel of a waiting detect
        det_en = 1'b0; det_pin = 1'b1;
        idle(5);
        step(1'b1, 1'b0); step(1'b1, 1'b0);
        chk("R1", "edge while disabled", det_pulse, 0);
        det_pin = 1'b0; det_en = 1'b1;
        idle(5);
        det_pin = 1'b1; idle(5);
        step(1'b1, 1'b0);
        det_en = 1'b0; idle(1);
        det_en = 1'b1; idle(1);
        step(1'b1, 1'b0);
        chk("R1", "cancelled first strobe", det_pulse, 0);
        step(1'b1, 1'b0);
        chk("R1", "cancelled second strobe", det_pulse, 0);
        det_pin = 1'b0;
        idle(5);

        // R4 R5 abort from the pin
        abort_pin = 1'b1;
        idle(5);
        step(1'b1, 1'b0);
        chk("R4", "no abort on first strobe", abort_pulse, 0);
        step(1'b1, 1'b0);
        chk("R4", "abort on second strobe", abort_pulse, 1);
        chk("R5", "inactive after abort", cnt_active, 0);
        chk("R5", "counters cleared", sym_cnt | smp_cnt | miss_cnt, 0);
        step(1'b0, 1'b0);
        chk("R4", "abort one cycle", abort_pulse, 0);
        abort_pin = 1'b0;
        // R6 strobes while inactive
        step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0);
        chk("R6", "idle counters", sym_cnt | smp_cnt | miss_cnt, 0);
        chk("R6", "stays inactive", cnt_active, 0);
        idle(3);

        // R5 abort against preamble detect at the same edge
        step(1'b0, 1'b1);
        chk("R7", "preamble reactivates", cnt_active, 1);
        abort_reg = 1'b1; idle(5);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        chk("R5", "abort wins over preamble", cnt_active, 0);
        chk("R5", "sym_cnt after tie", sym_cnt, 0);
        abort_reg = 1'b0;
        idle(5);

        // R5 abort (register bit) against manual detect at the same edge
        step(1'b0, 1'b1);
        det_pin = 1'b1; abort_reg = 1'b1;
        idle(5);
        step(1'b1, 1'b0); step(1'b1, 1'b0);
        chk("R5", "detect pulse in tie", det_pulse, 1);
        chk("R5", "abort pulse in tie", abort_pulse, 1);
        chk("R5", "inactive after tie", cnt_active, 0);
        chk("R5", "counters after tie", sym_cnt | smp_cnt | miss_cnt, 0);
        det_pin = 1'b0; abort_reg = 1'b0;
        idle(5);

        // R7 symbol counter saturation
        for (int i = 0; i < 300; i++) step(1'b0, 1'b1);
        chk("R7", "sym_cnt saturates", sym_cnt, 255);

        // R8 missed detect saturation with sym_len = 1
        sym_len = 8'd1;
        for (int i = 0; i < 300; i++) step(1'b1, 1'b0);
        chk("R8", "miss_cnt saturates", miss_cnt, 255);
        chk("R8", "smp_cnt wraps", smp_cnt, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule